// File: doc/BRIEF.md
# Selectable Memory Port with Output Enable

This block is a small synchronous read/write memory behind a bus-style output stage. An active-low select input, `cs_n`, gates all internal activity. An active-low output enable, `oe_n`, gates only the final drivers. `dout` carries the read word, and `dout_en` carries a per-bit drive enable, so that several such ports can share one set of data lines.

While the port is deselected, no internal access runs and the outputs stay released. When the port is selected with a read address, an internal access starts and takes `LAT_CS` clock edges to finish. That internal access keeps running even while `oe_n` is high. If the output enable is asserted after the access has already finished, the word appears after only `LAT_OE` edges. This gives the port two read latencies: a long one counted from select plus address, and a short one counted from output enable. A `busy` flag marks an internal access that is still in flight. A `valid` flag marks the cycles in which the port drives correct data.

Top module: `oe_mem_port`

## Requirements
- R1: When reset is released, `dout_en` is all zeros, `valid` is 0 and `busy` is 0.
- R2: While `cs_n` is 1, `dout_en` is all zeros and `valid` is 0, whatever the values of `oe_n`, `we` and `addr`; `dout` shows Z.
- R3: A rising edge with `cs_n`=0 and `we`=1 stores `wdata` at `addr`. In any cycle with `cs_n`=0 and `we`=1, `dout_en` is all zeros.
- R4: A read access starts with `cs_n`=0, `we`=0, a stable `addr` and `oe_n`=0. The first cycle in which the port drives is the one after the `LAT_CS`-th rising edge; in that cycle `dout` equals the word stored at `addr`.
- R5: With `cs_n`=0 and `oe_n`=1, the internal access still completes after `LAT_CS` edges, shown by `busy` falling, while `dout_en` stays all zeros.
- R6: Suppose the internal access has completed and `oe_n` then goes to 0 while the port stays selected. The port drives the word after `LAT_OE` rising edges, which is fewer than `LAT_CS`.
- R7: A rising edge with `cs_n`=1 abandons any pending access, so `busy` is 0 after it. A later reselect needs the full `LAT_CS` edges again.
- R8: A change of `addr` while the port is selected restarts the long access. Data for the new address is driven only after `LAT_CS` edges counted from the first edge that sees it.
- R9: `busy` is 1 after edges 1 through `LAT_CS-1` of an access and 0 after edge `LAT_CS` and later.
- R10: `valid` is 1 exactly when `dout_en` is all ones, and `dout_en` is only ever all zeros or all ones. Raising `oe_n` clears `valid` and `dout_en` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Port select, active low |
| oe_n | input | 1 | Output driver enable, active low |
| we | input | 1 | Write strobe, active high |
| addr | input | AW | Word address |
| wdata | input | DW | Write word |
| dout | output | DW | Read word, Z when released |
| dout_en | output | DW | Per-bit drive enable |
| busy | output | 1 | Internal access in flight |
| valid | output | 1 | Port is driving correct data |

## Verification
The bench applies inputs just after a falling edge and reads the outputs at the next falling edge, so each sample reflects exactly one more rising edge. Busy is due one edge after an access starts and drops on edge `LAT_CS`. Data with the enable held low is due on edge `LAT_CS`, and data after a late enable is due `LAT_OE` edges after `oe_n` falls. Deselection, write cycles and a raised enable take effect combinationally in the same sample. A bench model counts edges since the access started and since the enable fell, and compares every cycle against these counts. Directed sequences also check the cycle before and the cycle of each expected change.

// File: rtl/oe_mem_port.sv
module oe_mem_port #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int LAT_CS = 4,
  parameter int LAT_OE = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] dout,
  output logic [DW-1:0] dout_en,
  output logic          busy,
  output logic          valid
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = $clog2(LAT_CS + 1);
  localparam int OW    = $clog2(LAT_OE + 1);

  logic [DW-1:0] mem [DEPTH];
  logic          act, done;
  logic [CW-1:0] cnt;
  logic [AW-1:0] cur;
  logic [DW-1:0] rd;
  logic [OW-1:0] oe_cnt;

  wire rd_req = ~cs_n & ~we;
  wire start  = rd_req & (~act | (addr != cur));
  wire oe_ok  = (oe_cnt == OW'(LAT_OE));
  wire drive  = rd_req & ~oe_n & done & oe_ok;

  always_ff @(posedge clk)
    if (!cs_n && we) mem[addr] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      cur  <= '0;
      rd   <= '0;
    end else if (!rd_req) begin
      act  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      act  <= 1'b1;
      done <= 1'b0;
      cur  <= addr;
      cnt  <= CW'(1);
    end else if (!done) begin
      cnt <= cnt + CW'(1);
      if (cnt + CW'(1) == CW'(LAT_CS)) begin
        done <= 1'b1;
        rd   <= mem[cur];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                oe_cnt <= '0;
    else if (!rd_req || oe_n)  oe_cnt <= '0;
    else if (!oe_ok)           oe_cnt <= oe_cnt + OW'(1);
  end

  assign busy    = act & ~done;
  assign valid   = drive;
  assign dout_en = {DW{drive}};
  assign dout    = drive ? rd : 'z;
endmodule

// File: rtl/oe_mem_port_chk.sv
module oe_mem_port_chk #(
  parameter int AW     = 4,
  parameter int DW     = 8,
  parameter int LAT_CS = 4,
  parameter int LAT_OE = 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          oe_n,
  input logic          we,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] dout_en,
  input logic          busy,
  input logic          valid
);
  logic [7:0]    run, oe_run;
  logic [AW-1:0] last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= '0; oe_run <= '0; last <= '0;
    end else begin
      if (cs_n || we) run <= '0;
      else if (run == 0 || addr != last) begin run <= 8'd1; last <= addr; end
      else if (run != 8'hff) run <= run + 8'd1;
      if (cs_n || we || oe_n) oe_run <= '0;
      else if (oe_run != 8'hff) oe_run <= oe_run + 8'd1;
    end
  end

  AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dout_en == '0 && !valid)); // R2
  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && we) |-> (dout_en == '0)); // R3
  AST_LONG_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (run >= 8'(LAT_CS))); // R4
  AST_SHORT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (oe_run >= 8'(LAT_OE))); // R6
  AST_ABANDON: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !busy); // R7
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (valid == (&dout_en)) && (dout_en == '0 || &dout_en)); // R10
  AST_OE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !valid); // R10
endmodule

bind oe_mem_port oe_mem_port_chk #(.AW(AW), .DW(DW), .LAT_CS(LAT_CS), .LAT_OE(LAT_OE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we(we), .addr(addr),
  .dout_en(dout_en), .busy(busy), .valid(valid));

// File: tb/oe_mem_port_bench.sv
`timescale 1ns/1ps
module oe_mem_port_bench;
  localparam int AW = 4, DW = 8, LAT_CS = 4, LAT_OE = 1;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] dout, dout_en;
  logic busy, valid;
  int total = 0, bad = 0;

  always #2 clk = ~clk;

  oe_mem_port #(.AW(AW), .DW(DW), .LAT_CS(LAT_CS), .LAT_OE(LAT_OE)) u_oe_mem_port (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .oe_n(oe_n), .we(we), .addr(addr),
    .wdata(wdata), .dout(dout), .dout_en(dout_en), .busy(busy), .valid(valid));

  logic [DW-1:0] m_mem [DEPTH];
  logic          m_act = 1'b0;
  logic [AW-1:0] m_cur = '0;
  int            m_cnt = 0, m_oe = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit exp_drive();
    return !cs_n && !we && !oe_n && m_cnt >= LAT_CS && m_oe >= LAT_OE;
  endfunction

  function automatic bit exp_busy();
    return m_act && m_cnt < LAT_CS;
  endfunction

  task automatic model_edge();
    if (!cs_n && we) m_mem[addr] = wdata;
    if (cs_n || we) begin m_act = 1'b0; m_cnt = 0; end
    else if (!m_act || addr != m_cur) begin m_act = 1'b1; m_cur = addr; m_cnt = 1; end
    else m_cnt++;
    if (cs_n || we || oe_n) m_oe = 0; else m_oe++;
  endtask

  task automatic cyc(logic c, logic o, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    cs_n = c; oe_n = o; we = w; addr = a; wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R10 model drive", {31'd0, valid}, {31'd0, exp_drive()});
    chk("R10 enable pattern", {24'd0, dout_en}, exp_drive() ? 32'hff : 32'h0);
    chk("R9 model busy", {31'd0, busy}, {31'd0, exp_busy()});
    if (exp_drive()) chk("R4 model data", {24'd0, dout}, {24'd0, m_mem[m_cur]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 enable after reset", {24'd0, dout_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid", {31'd0, valid}, 0);
    chk("R1 busy", {31'd0, busy}, 0);
    // R3: fill the memory; drive must stay off while writing
    for (int i = 0; i < DEPTH; i++) begin
      cyc(1'b0, 1'b0, 1'b1, AW'(i), DW'(8'h30 + i * 7));
      chk("R3 no drive in write", {24'd0, dout_en}, 0);
    end
    cyc(1'b1, 1'b0, 1'b0, 0, 0);
    chk("R2 deselected", {31'd0, valid}, 0);
    // R4: long latency with oe low
    for (int k = 1; k <= LAT_CS; k++) begin
      cyc(1'b0, 1'b0, 1'b0, 4'd5, 0);
      chk("R4 long latency", {31'd0, valid}, {31'd0, k >= LAT_CS});
      chk("R9 busy window", {31'd0, busy}, {31'd0, k < LAT_CS});
    end
    chk("R4 data", {24'd0, dout}, 8'h30 + 5 * 7);
    cyc(1'b0, 1'b1, 1'b0, 4'd5, 0);
    chk("R10 oe raise clears", {31'd0, valid}, 0);
    cyc(1'b1, 1'b0, 1'b0, 4'd5, 0);
    // R5 and R6: access with oe high, then late enable
    for (int k = 1; k <= LAT_CS + 2; k++) begin
      cyc(1'b0, 1'b1, 1'b0, 4'd9, 0);
      chk("R5 no drive", {24'd0, dout_en}, 0);
      chk("R5 busy", {31'd0, busy}, {31'd0, k < LAT_CS});
    end
    for (int k = 1; k <= LAT_OE; k++) begin
      cyc(1'b0, 1'b0, 1'b0, 4'd9, 0);
      chk("R6 short latency", {31'd0, valid}, {31'd0, k >= LAT_OE});
    end
    chk("R6 data", {24'd0, dout}, 8'h30 + 9 * 7);
    // R7: abandon mid-access
    cyc(1'b1, 1'b0, 1'b0, 4'd2, 0);
    cyc(1'b0, 1'b0, 1'b0, 4'd2, 0);
    cyc(1'b0, 1'b0, 1'b0, 4'd2, 0);
    cyc(1'b1, 1'b0, 1'b0, 4'd2, 0);
    chk("R7 busy cleared", {31'd0, busy}, 0);
    chk("R2 released", {24'd0, dout_en}, 0);
    for (int k = 1; k <= LAT_CS; k++) begin
      cyc(1'b0, 1'b0, 1'b0, 4'd2, 0);
      chk("R7 full restart", {31'd0, valid}, {31'd0, k >= LAT_CS});
    end
    // R8: address change restarts
    for (int k = 1; k <= LAT_CS; k++) begin
      cyc(1'b0, 1'b0, 1'b0, 4'd11, 0);
      chk("R8 restart", {31'd0, valid}, {31'd0, k >= LAT_CS});
    end
    chk("R8 data", {24'd0, dout}, 8'h30 + 11 * 7);
    // R3: overwrite then read back
    cyc(1'b0, 1'b0, 1'b1, 4'd11, 8'hc5);
    for (int k = 1; k <= LAT_CS; k++) cyc(1'b0, 1'b0, 1'b0, 4'd11, 0);
    chk("R3 write stored", {24'd0, dout}, 8'hc5);
    // random phase
    void'($urandom(32'h5eed));
    begin
      logic [AW-1:0] ra = '0;
      for (int n = 0; n < 600; n++) begin
        if ($urandom % 8 == 0) ra = AW'($urandom);
        cyc(($urandom % 10) == 0, ($urandom % 3) == 0, ($urandom % 12) == 0, ra, DW'($urandom));
        if (cs_n) chk("R2 random deselect", {24'd0, dout_en}, 0);
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule